// File: doc/BRIEF.md
# Output-Compare PWM Generator

This block produces a pulse-width modulated waveform from a free-running counter and two comparators. One comparator holds the on-time and the other holds the period. Software writes a small register port to choose the waveform shape, the sync source, the polarity and the fault response. It also writes shadow copies of the on-time, the period and a 2-bit fine-duty value. The shadow copies pass into the active compare registers only on the cycle the counter restarts from zero, so a waveform that is already running never shows a partial or torn pulse.

The counter advances only while `ce` is high. When the sync-select field holds the reserved code 5'h1F, a period match restarts the counter. With any other code the counter runs through its full range, and the `sync_in` pulse restarts it. A one-clock interrupt marks every period match. When `fault_in` goes high, the output is forced to a programmed safe level, or the output enable is dropped instead. This fault state is held until software clears it.

Register map on `wr_addr`:
- 0 is control: bits [1:0] select the waveform (1 edge-aligned, 2 center-aligned, 0 or 3 off), bit 2 inverts the output, bit 3 selects tri-state on fault, bit 4 is the safe level, and bits [9:5] are the sync select. Bit 15 is a write-one fault clear and is not stored.
- 1 is the on-time shadow.
- 2 is the period shadow.
- 3 is the fine-duty shadow in bits [1:0].

Top module: `ocpwm_top`

## Requirements
- R1: After reset, `pwm_out` is 0, `pwm_oe` is 1, `irq` is 0 and `fault_active` is 0.
- R2: In edge-aligned mode (mode 1), `pwm_out` after a clock edge reflects the counter value held before that edge, and it is high while that value is below the active on-time. An on-time of 0 gives a constant low, and an on-time above the period gives a constant high.
- R3: In center-aligned mode (mode 2), the registered output is high while the counter lies between the active on-time and the active period, both included.
- R4: A write to an on-time, period or fine-duty shadow reaches the comparators only at the next counter restart. A write sampled on the same edge as a restart waits for the restart after that.
- R5: With sync select 5'h1F, the counter restarts after matching the active period, so each period lasts period+1 enabled clocks.
- R6: With any other sync select, the counter wraps from all-ones to zero. A `sync_in` high on an enabled edge restarts the counter at zero, and both events load the shadows.
- R7: A 2-bit frame number advances at each counter restart. In edge-aligned mode with a nonzero on-time, the pulse is one clock longer in every frame whose number is below the active fine-duty value.
- R8: Control bit 2 inverts the waveform. When the mode is off the waveform is low, so `pwm_out` then equals the invert bit.
- R9: While `fault_in` is high, or while the latched fault is set, `pwm_out` is driven to control bit 4 one edge later. `fault_active` shows the latch, which holds after `fault_in` falls, and normal output resumes after the latch is cleared.
- R10: The fault latch clears only on a control write with bit 15 set that is sampled while `fault_in` is low.
- R11: With control bit 3 set, `pwm_oe` is 0 from the edge after the fault appears until the edge after the latch clears. With bit 3 clear, `pwm_oe` stays 1.
- R12: `irq` is high for the one clock following each enabled edge at which the counter equals the active period.
- R13: While `ce` is low, the counter and the waveform hold, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| sync_in | input | 1 | External counter restart |
| fault_in | input | 1 | Fault request |
| pwm_out | output | 1 | Registered PWM output |
| pwm_oe | output | 1 | Output enable (0 means tri-state) |
| irq | output | 1 | One-clock period-match interrupt |
| fault_active | output | 1 | Latched fault status |

## Verification
The bench builds the block with a 6-bit counter. This narrow width brings the free-running wrap at 64 within a short run, next to an external sync restart. It also allows a full sweep of self-synced periods 0 to 7 against on-times 0 to 9 and every fine-duty value, so the constant-low, constant-high and on-time-above-period corners all occur. Expected levels come from the cycle index alone, through the period arithmetic. Directed runs place shadow writes in the middle of a period and on the restart edge itself, pause the clock enable, and walk the fault latch through a rejected clear and an accepted clear.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;

    localparam int DATA_W  = 16;
    localparam int CLR_BIT = 15;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_ON   = 2'd1;
    localparam logic [1:0] ADDR_PER  = 2'd2;
    localparam logic [1:0] ADDR_FINE = 2'd3;

    localparam logic [4:0] SYNC_SELF = 5'h1F;

    typedef enum logic [1:0] {
        WAVE_OFF    = 2'd0,
        WAVE_EDGE   = 2'd1,
        WAVE_CENTER = 2'd2,
        WAVE_RSVD   = 2'd3
    } wave_e;

    typedef struct packed {
        logic [4:0] sync_sel;
        logic       safe_lvl;
        logic       tris_on_fault;
        logic       invert;
        wave_e      wave;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.wave          = wave_e'(d[1:0]);
        c.invert        = d[2];
        c.tris_on_fault = d[3];
        c.safe_lvl      = d[4];
        c.sync_sel      = d[9:5];
        return c;
    endfunction

endpackage

// File: rtl/ocpwm_regs.sv
module ocpwm_regs
    import ocpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rollover,
    output ctrl_t               ctrl_q,
    output logic [CNT_W-1:0]    on_act,
    output logic [CNT_W-1:0]    per_act,
    output logic [1:0]          fine_act,
    output logic                fault_clr
);

    logic [CNT_W-1:0] on_sh;
    logic [CNT_W-1:0] per_sh;
    logic [1:0]       fine_sh;

    assign fault_clr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            on_sh    <= '0;
            per_sh   <= '0;
            fine_sh  <= '0;
            on_act   <= '0;
            per_act  <= '0;
            fine_act <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    ADDR_CTRL: ctrl_q  <= unpack_ctrl(wr_data);
                    ADDR_ON:   on_sh   <= wr_data[CNT_W-1:0];
                    ADDR_PER:  per_sh  <= wr_data[CNT_W-1:0];
                    default:   fine_sh <= wr_data[1:0];
                endcase
            end
            if (rollover) begin
                on_act   <= on_sh;
                per_act  <= per_sh;
                fine_act <= fine_sh;
            end
        end
    end

endmodule

// File: rtl/ocpwm_timebase.sv
module ocpwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             self_sync,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic [1:0]       frame,
    output logic             per_match,
    output logic             rollover
);

    logic restart;

    assign per_match = (cnt == per_act);

    always_comb begin
        if (self_sync) restart = per_match;
        else           restart = sync_in | (&cnt);
        rollover = ce & restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            frame <= '0;
        end else if (ce) begin
            if (restart) begin
                cnt   <= '0;
                frame <= frame + 2'd1;
            end else begin
                cnt   <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ocpwm_wave.sv
module ocpwm_wave
    import ocpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_q,
    input  logic             ce,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       frame,
    input  logic [CNT_W-1:0] on_act,
    input  logic [CNT_W-1:0] per_act,
    input  logic [1:0]       fine_act,
    input  logic             per_match,
    input  logic             fault_in,
    input  logic             fault_clr,
    output logic             pwm_out,
    output logic             pwm_oe,
    output logic             irq,
    output logic             fault_active
);

    localparam int CMP_W = CNT_W + 1;

    logic             stretch;
    logic [CMP_W-1:0] on_eff;
    logic             raw;
    logic             force_safe;

    assign stretch    = (frame < fine_act) && (on_act != '0);
    assign on_eff     = {1'b0, on_act} + {{CNT_W{1'b0}}, stretch};
    assign force_safe = fault_in | fault_active;

    always_comb begin
        case (ctrl_q.wave)
            WAVE_EDGE:   raw = ({1'b0, cnt} < on_eff);
            WAVE_CENTER: raw = (cnt >= on_act) && (cnt <= per_act);
            default:     raw = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out      <= 1'b0;
            pwm_oe       <= 1'b1;
            irq          <= 1'b0;
            fault_active <= 1'b0;
        end else begin
            fault_active <= fault_in | (fault_active & ~fault_clr);
            irq          <= ce & per_match;
            pwm_out      <= force_safe ? ctrl_q.safe_lvl : (raw ^ ctrl_q.invert);
            pwm_oe       <= ~(force_safe & ctrl_q.tris_on_fault);
        end
    end

endmodule

// File: rtl/ocpwm_top.sv
module ocpwm_top
    import ocpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sync_in,
    input  logic              fault_in,
    output logic              pwm_out,
    output logic              pwm_oe,
    output logic              irq,
    output logic              fault_active
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] on_act;
    logic [CNT_W-1:0] per_act;
    logic [1:0]       fine_act;
    logic             fault_clr;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       frame;
    logic             per_match;
    logic             rollover;
    logic             self_sync;

    assign self_sync = (ctrl_q.sync_sel == SYNC_SELF);

    ocpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rollover  (rollover),
        .ctrl_q    (ctrl_q),
        .on_act    (on_act),
        .per_act   (per_act),
        .fine_act  (fine_act),
        .fault_clr (fault_clr)
    );

    ocpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .self_sync (self_sync),
        .sync_in   (sync_in),
        .per_act   (per_act),
        .cnt       (cnt),
        .frame     (frame),
        .per_match (per_match),
        .rollover  (rollover)
    );

    ocpwm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk          (clk),
        .rst          (rst),
        .ctrl_q       (ctrl_q),
        .ce           (ce),
        .cnt          (cnt),
        .frame        (frame),
        .on_act       (on_act),
        .per_act      (per_act),
        .fine_act     (fine_act),
        .per_match    (per_match),
        .fault_in     (fault_in),
        .fault_clr    (fault_clr),
        .pwm_out      (pwm_out),
        .pwm_oe       (pwm_oe),
        .irq          (irq),
        .fault_active (fault_active)
    );

endmodule

// File: rtl/ocpwm_chk.sv
module ocpwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic             sync_in,
    input logic             fault_in,
    input logic             self_sync,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] on_act,
    input logic [CNT_W-1:0] per_act,
    input logic             rollover,
    input logic             fault_active,
    input logic             safe_lvl,
    input logic             tris,
    input logic             pwm_out,
    input logic             pwm_oe
);

    assert_load_at_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(on_act) || !$stable(per_act)) |-> $past(rollover));

    assert_self_sync_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (ce && self_sync && (cnt == per_act)) |=> (cnt == '0));

    assert_free_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (ce && !self_sync && !sync_in && (&cnt)) |=> (cnt == '0));

    assert_fault_level_R9: assert property (@(posedge clk) disable iff (rst)
        fault_active |=> (pwm_out == $past(safe_lvl)));

    assert_fault_wins_clear_R10: assert property (@(posedge clk) disable iff (rst)
        fault_in |=> fault_active);

    assert_tristate_R11: assert property (@(posedge clk) disable iff (rst)
        (fault_active && tris) |=> !pwm_oe);

    assert_hold_when_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(cnt));

endmodule

bind ocpwm_top ocpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ce           (ce),
    .sync_in      (sync_in),
    .fault_in     (fault_in),
    .self_sync    (self_sync),
    .cnt          (cnt),
    .on_act       (on_act),
    .per_act      (per_act),
    .rollover     (rollover),
    .fault_active (fault_active),
    .safe_lvl     (ctrl_q.safe_lvl),
    .tris         (ctrl_q.tris_on_fault),
    .pwm_out      (pwm_out),
    .pwm_oe       (pwm_oe)
);

// File: tb/sim_ocpwm_top.sv
module sim_ocpwm_top;

    localparam int W = 6;
    localparam int M = 1 << W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        sync_in = 1'b0;
    logic        fault_in = 1'b0;
    logic        pwm_out, pwm_oe, irq, fault_active;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ocpwm_top #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .fault_in(fault_in),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq), .fault_active(fault_active)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mk_ctrl(int wave, int inv, int tris, int safe, int sel, int clr);
        return 16'((wave & 3) | (inv << 2) | (tris << 3) | (safe << 4) | ((sel & 31) << 5) | (clr << 15));
    endfunction

    function automatic int exp_raw(int wave, int c, int o, int p, int fr, int d);
        if (wave == 1) begin
            if (o == 0) return 0;
            return (c < o + ((fr < d) ? 1 : 0)) ? 1 : 0;
        end
        if (wave == 2) return (c >= o && c <= p) ? 1 : 0;
        return 0;
    endfunction

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; ce = 1'b0; wr_en = 1'b0; sync_in = 1'b0; fault_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic run_sweep(int p, int o1, int o2, int wr_k, int swp, int d,
                             int wave, int inv, int kmax, string req);
        ce = 1'b1;
        for (int k = 1; k <= kmax; k++) begin
            step();
            if (k >= 2) begin
                int n, pi, c, ov, fr, e;
                n  = k - 2;
                pi = n / (p + 1);
                c  = n % (p + 1);
                ov = (pi < swp) ? o1 : o2;
                fr = (1 + pi) % 4;
                e  = exp_raw(wave, c, ov, p, fr, d) ^ inv;
                chk(pwm_out === 1'(e), req, "pwm_out", int'(pwm_out), e);
                chk(irq === (c == p), "R5 R12", "irq", int'(irq), int'(c == p));
            end
            if (k == wr_k) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'(o2);
            end else begin
                wr_en = 1'b0;
            end
        end
        ce = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic setup(int wave, int inv, int sel, int o, int p, int d);
        do_reset();
        wr(2'd0, mk_ctrl(wave, inv, 0, 0, sel, 0));
        wr(2'd1, 16'(o));
        wr(2'd2, 16'(p));
        wr(2'd3, 16'(d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: R1 run ended got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk(pwm_out === 1'b0, "R1", "pwm_out", int'(pwm_out), 0);
        chk(pwm_oe === 1'b1, "R1", "pwm_oe", int'(pwm_oe), 1);
        chk(irq === 1'b0, "R1", "irq", int'(irq), 0);
        chk(fault_active === 1'b0, "R1", "fault_active", int'(fault_active), 0);

        // R2 R7 R8: edge-aligned sweep; R3: center-aligned sweep
        for (int p = 0; p < 8; p++) begin
            for (int o = 0; o < 10; o++) begin
                for (int d = 0; d < 4; d++) begin
                    int inv;
                    inv = (p + o + d) & 1;
                    setup(1, inv, 31, o, p, d);
                    run_sweep(p, o, o, 0, 99, d, 1, inv, 4 * (p + 1) + 2,
                              (d != 0) ? "R7" : ((inv != 0) ? "R2 R8" : "R2"));
                end
                setup(2, (p + o) & 1, 31, o, p, 0);
                run_sweep(p, o, o, 0, 99, 0, 2, (p + o) & 1, 3 * (p + 1) + 2, "R3");
            end
        end

        // R4: write in mid-period applies from the next period
        setup(1, 0, 31, 3, 9, 0);
        run_sweep(9, 3, 7, 5, 1, 0, 1, 0, 35, "R4 mid-period");
        // R4: write sampled on the restart edge waits one more period
        setup(1, 0, 31, 3, 9, 0);
        run_sweep(9, 3, 7, 10, 2, 0, 1, 0, 35, "R4 same-edge");

        // R8: mode off leaves output at the invert level
        setup(0, 1, 31, 3, 9, 0);
        ce = 1'b1;
        repeat (12) begin
            step();
            chk(pwm_out === 1'b1, "R8", "pwm_out off+inv", int'(pwm_out), 1);
        end
        ce = 1'b0;

        // R6: free-running wrap at 64, then external sync restart at edge 150
        setup(1, 0, 0, 5, 20, 0);
        ce = 1'b1;
        for (int k = 1; k <= 220; k++) begin
            step();
            if (k >= 66) begin
                int j, c;
                j = k - 1;
                c = (j >= 150) ? (j - 150) % M : j % M;
                chk(pwm_out === (c < 5), "R6", "pwm_out", int'(pwm_out), int'(c < 5));
                chk(irq === (c == 20), "R6 R12", "irq", int'(irq), int'(c == 20));
            end
            sync_in = (k == 149);
        end
        ce = 1'b0;
        sync_in = 1'b0;

        // R13: clock enable paused for edges 15..19
        setup(1, 0, 31, 4, 9, 0);
        ce = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            step();
            if (k >= 2) begin
                int j, cj;
                bit cek;
                j = k - 1;
                cj = (j <= 14) ? (j - 1) % 10 : ((j <= 19) ? 3 : (j - 6) % 10);
                cek = !(k >= 15 && k <= 19);
                chk(pwm_out === (cj < 4), "R13", "pwm_out", int'(pwm_out), int'(cj < 4));
                chk(irq === (cek && cj == 9), "R13", "irq", int'(irq), int'(cek && cj == 9));
            end
            ce = !((k + 1) >= 15 && (k + 1) <= 19);
        end
        ce = 1'b0;

        // R9 R10 R11: fault handling
        do_reset();
        wr(2'd0, mk_ctrl(1, 0, 0, 1, 31, 0));
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd9);
        ce = 1'b1;
        repeat (25) step();
        fault_in = 1'b1;
        step();
        chk(fault_active === 1'b1, "R9", "fault_active", int'(fault_active), 1);
        chk(pwm_out === 1'b1, "R9", "pwm_out safe", int'(pwm_out), 1);
        chk(pwm_oe === 1'b1, "R11", "pwm_oe drive", int'(pwm_oe), 1);
        fault_in = 1'b0;
        repeat (10) begin
            step();
            chk(pwm_out === 1'b1, "R9", "pwm_out latched", int'(pwm_out), 1);
            chk(fault_active === 1'b1, "R9", "fault_active latched", int'(fault_active), 1);
        end
        fault_in = 1'b1;
        wr(2'd0, mk_ctrl(1, 0, 0, 1, 31, 1));
        chk(fault_active === 1'b1, "R10", "clear during fault", int'(fault_active), 1);
        fault_in = 1'b0;
        step();
        chk(fault_active === 1'b1, "R10", "no clear without write", int'(fault_active), 1);
        wr(2'd0, mk_ctrl(1, 0, 0, 1, 31, 1));
        chk(fault_active === 1'b0, "R10", "clear accepted", int'(fault_active), 0);
        step();
        begin
            int highs;
            highs = 0;
            repeat (10) begin
                step();
                highs += int'(pwm_out);
            end
            chk(highs == 4, "R9", "high count after recovery", highs, 4);
        end
        wr(2'd0, mk_ctrl(1, 0, 1, 0, 31, 0));
        fault_in = 1'b1;
        step();
        chk(pwm_oe === 1'b0, "R11", "pwm_oe tri", int'(pwm_oe), 0);
        chk(pwm_out === 1'b0, "R9", "pwm_out safe low", int'(pwm_out), 0);
        fault_in = 1'b0;
        repeat (3) begin
            step();
            chk(pwm_oe === 1'b0, "R11", "pwm_oe latched", int'(pwm_oe), 0);
        end
        wr(2'd0, mk_ctrl(1, 0, 1, 0, 31, 1));
        step();
        chk(pwm_oe === 1'b1, "R11", "pwm_oe restored", int'(pwm_oe), 1);
        ce = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule